// File: doc/BRIEF.md
# Programmable-Priority Interrupt Winner Resolver

This block keeps a software-loaded table of 40 rank slots. Each slot names one interrupt source and carries a valid flag. The slot's index is its rank, and index 0 is the most urgent. On request the block works out two winners. One is the most urgent source that is pending, enabled and steered to the fast-interrupt line (FIQ). The other is the most urgent source that is pending, enabled and steered to the normal line (IRQ). Both winners are packed into one 32-bit status word, and each half has its own valid flag.

The pending, enable and steering vectors come from a neighbouring mask/router block in two banks. The low bank carries sources 0 to 31. The high bank carries sources 32 to 39 on its bits 0 to 7. Software uses a simple register port. A slot read or a slot write completes in one cycle. A status read samples the three vectors at the request, walks the table one slot per clock while `regBusy` is high, and then presents the word with a one-cycle `regRdValid` pulse.

Top module: `prio_resolver`

## Requirements
- R1: After reset every slot reads zero (so every slot is invalid), `regBusy` and `regRdValid` are low, and a status read returns 0x003F003F.
- R2: A slot write keeps only bit 31 (valid) and bits 5:0 (source ID), so a written value reads back ANDed with 0x8000003F. Slot n < 32 lives at byte offset 0x1C+4n, and slot n ≥ 32 lives at 0xB0+4(n−32).
- R3: When idle, a read of a slot or of any unmapped offset raises `regRdValid` for exactly one cycle, on the cycle after the request, and `regBusy` stays low. Unmapped offsets read 0. Writes to the status offset (0x18) or to unmapped offsets change no slot. A slot read in the same cycle as a write to that slot returns the old value.
- R4: A status read at offset 0x18 raises `regBusy` from the next cycle for exactly 41 cycles (one per slot plus one). `regRdValid` then pulses while `regBusy` is low.
- R5: A slot takes part only if its valid bit is set and its source ID is below 40. Any other slot is skipped.
- R6: Among the slots that take part, the lowest slot index wins, separately for each half.
- R7: A source counts for the FIQ half when it is pending, enabled and has steering bit 1, and for the IRQ half when it is pending, enabled and has steering bit 0. The FIQ winner's ID sits in bits 5:0 with its valid flag in bit 15. The IRQ winner's ID sits in bits 21:16 with its valid flag in bit 31. All other bits are 0.
- R8: A half with no candidate reads ID 0x3F with its valid flag clear.
- R9: Source IDs 32 to 39 use bits 0 to 7 of the high-bank vectors. IDs 0 to 31 use the low bank.
- R10: The result depends only on the pending, enable and steering vectors sampled in the request cycle. Changes to them while `regBusy` is high have no effect on it.
- R11: Reads and writes presented while `regBusy` is high are dropped: no slot changes and no extra `regRdValid` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write request |
| regRdEn | input | 1 | Register read request |
| regAddr | input | 8 | Byte offset of the access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, meaningful while regRdValid is high |
| regRdValid | output | 1 | One-cycle read-data strobe |
| regBusy | output | 1 | Status evaluation in progress |
| pendLo | input | 32 | Pending, sources 0 to 31 |
| pendHi | input | 8 | Pending, sources 32 to 39 |
| enLo | input | 32 | Enable, sources 0 to 31 |
| enHi | input | 8 | Enable, sources 32 to 39 |
| fiqLo | input | 32 | Steering to FIQ (1) or IRQ (0), sources 0 to 31 |
| fiqHi | input | 8 | Steering, sources 32 to 39 |

## Verification
The assertions watch the handshake on every cycle:
- the length of the busy window;
- that busy starts only from a status request;
- the one-cycle latency of slot reads;
- that read data never appears while busy;
- the padding bits of every status word;
- the 0x3F-with-flag-clear form of an empty half.

Which source actually wins cannot be seen from the ports without a model. That is shown only by the bench scenarios:
- rank ordering and the skipping of invalid slots;
- the bank split for IDs 32 to 39;
- FIQ/IRQ steering;
- masked slot storage;
- the immunity to input changes and register accesses during an evaluation.

// File: rtl/prio_resolver_pkg.sv
package prio_resolver_pkg;
  localparam int DEF_NUM_SRC = 40;
  localparam int LO_SRC      = 32;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 32;
  localparam int ID_W        = 6;

  localparam logic [ADDR_W-1:0] STAT_OFS = 8'h18;
  localparam logic [ADDR_W-1:0] LO_BASE  = 8'h1C;
  localparam logic [ADDR_W-1:0] HI_BASE  = 8'hB0;

  localparam int SLOT_VLD_BIT = 31;
  localparam int FIQ_VLD_BIT  = 15;
  localparam int IRQ_ID_LSB   = 16;
  localparam int IRQ_VLD_BIT  = 31;

  localparam logic [ID_W-1:0] NONE_ID = '1;

  // strobes from control to datapath
  typedef struct packed {
    logic slotWr;
    logic regRead;
    logic snapLoad;
    logic scanStep;
    logic finish;
  } ctl_t;

  typedef struct packed {
    logic            valid;
    logic [ID_W-1:0] id;
  } slot_t;
endpackage

// File: rtl/prio_res_decode.sv
module prio_res_decode
  import prio_resolver_pkg::*;
#(
  parameter int NUM_SRC = DEF_NUM_SRC,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              isStatus,
  output logic              isSlot,
  output logic [IDX_W-1:0]  slotIdx
);
  localparam int HI_CNT  = NUM_SRC - LO_SRC;
  localparam int LO_BEG  = int'(LO_BASE);
  localparam int HI_BEG  = int'(HI_BASE);
  localparam int LO_END  = LO_BEG + 4 * LO_SRC;
  localparam int HI_END  = HI_BEG + 4 * HI_CNT;

  always_comb begin
    int aInt;
    aInt     = int'(addr);
    isStatus = (addr == STAT_OFS);
    isSlot   = 1'b0;
    slotIdx  = '0;
    if (addr[1:0] == 2'b00) begin
      if (aInt >= LO_BEG && aInt < LO_END) begin
        isSlot  = 1'b1;
        slotIdx = IDX_W'((aInt - LO_BEG) / 4);
      end else if (aInt >= HI_BEG && aInt < HI_END) begin
        isSlot  = 1'b1;
        slotIdx = IDX_W'(LO_SRC + (aInt - HI_BEG) / 4);
      end
    end
  end
endmodule

// File: rtl/prio_res_ctrl.sv
module prio_res_ctrl
  import prio_resolver_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic regRdEn,
  input  logic isStatus,
  input  logic lastSlot,
  output ctl_t ctl,
  output logic busy
);
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_DONE} state_t;

  state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        ctl.slotWr = regWrEn;
        if (regRdEn) begin
          if (isStatus) begin
            ctl.snapLoad = 1'b1;
            nextState    = S_SCAN;
          end else begin
            ctl.regRead  = 1'b1;
          end
        end
      end
      S_SCAN: begin
        ctl.scanStep = 1'b1;
        if (lastSlot) nextState = S_DONE;
      end
      S_DONE: begin
        ctl.finish = 1'b1;
        nextState  = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/prio_res_dp.sv
module prio_res_dp
  import prio_resolver_pkg::*;
#(
  parameter int NUM_SRC = DEF_NUM_SRC,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_t               ctl,
  input  logic               isSlot,
  input  logic [IDX_W-1:0]   slotIdx,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [NUM_SRC-1:0] pendIn,
  input  logic [NUM_SRC-1:0] enIn,
  input  logic [NUM_SRC-1:0] fiqIn,
  output logic               lastSlot,
  output logic [DATA_W-1:0]  regRdData,
  output logic               regRdValid
);
  slot_t              slotTab [NUM_SRC];
  logic [NUM_SRC-1:0] pendSnap, enSnap, fiqSnap;
  logic [IDX_W-1:0]   scanIdx;
  logic               fiqFound, irqFound;
  logic [ID_W-1:0]    fiqId, irqId;

  logic unusedWrBits;
  assign unusedWrBits = ^regWrData[SLOT_VLD_BIT-1:ID_W];

  // slot table, one register per rank
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotTab[g] <= '0;
      end else if (ctl.slotWr && isSlot && slotIdx == IDX_W'(g)) begin
        slotTab[g].valid <= regWrData[SLOT_VLD_BIT];
        slotTab[g].id    <= regWrData[ID_W-1:0];
      end
    end
  end

  // candidate test for the slot under the scan pointer
  slot_t curSlot;
  logic  curQual, srcLive, fiqHit, irqHit;

  always_comb begin
    curSlot = slotTab[scanIdx];
    curQual = curSlot.valid && (int'(curSlot.id) < NUM_SRC);
    srcLive = curQual && pendSnap[curSlot.id] && enSnap[curSlot.id];
    fiqHit  = srcLive && fiqSnap[curSlot.id];
    irqHit  = srcLive && !fiqSnap[curSlot.id];
  end

  assign lastSlot = (scanIdx == IDX_W'(NUM_SRC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSnap <= '0;
      enSnap   <= '0;
      fiqSnap  <= '0;
      scanIdx  <= '0;
      fiqFound <= 1'b0;
      irqFound <= 1'b0;
      fiqId    <= NONE_ID;
      irqId    <= NONE_ID;
    end else if (ctl.snapLoad) begin
      pendSnap <= pendIn;
      enSnap   <= enIn;
      fiqSnap  <= fiqIn;
      scanIdx  <= '0;
      fiqFound <= 1'b0;
      irqFound <= 1'b0;
      fiqId    <= NONE_ID;
      irqId    <= NONE_ID;
    end else if (ctl.scanStep) begin
      scanIdx <= scanIdx + 1'b1;
      if (fiqHit && !fiqFound) begin
        fiqFound <= 1'b1;
        fiqId    <= curSlot.id;
      end
      if (irqHit && !irqFound) begin
        irqFound <= 1'b1;
        irqId    <= curSlot.id;
      end
    end
  end

  logic [DATA_W-1:0] statusWord, slotWord;
  slot_t             rdSlot;

  always_comb begin
    statusWord                           = '0;
    statusWord[ID_W-1:0]                 = fiqId;
    statusWord[FIQ_VLD_BIT]              = fiqFound;
    statusWord[IRQ_ID_LSB +: ID_W]       = irqId;
    statusWord[IRQ_VLD_BIT]              = irqFound;
    rdSlot                               = isSlot ? slotTab[slotIdx] : '0;
    slotWord                             = '0;
    slotWord[ID_W-1:0]                   = rdSlot.id;
    slotWord[SLOT_VLD_BIT]               = rdSlot.valid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdData  <= '0;
      regRdValid <= 1'b0;
    end else begin
      regRdValid <= ctl.finish || ctl.regRead;
      if (ctl.finish)       regRdData <= statusWord;
      else if (ctl.regRead) regRdData <= slotWord;
    end
  end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_resolver_pkg::*;
#(
  parameter int NUM_SRC = DEF_NUM_SRC,
  parameter int HI_W    = NUM_SRC - LO_SRC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              regRdValid,
  output logic              regBusy,
  input  logic [LO_SRC-1:0] pendLo,
  input  logic [HI_W-1:0]   pendHi,
  input  logic [LO_SRC-1:0] enLo,
  input  logic [HI_W-1:0]   enHi,
  input  logic [LO_SRC-1:0] fiqLo,
  input  logic [HI_W-1:0]   fiqHi
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic             isStatus, isSlot, lastSlot;
  logic [IDX_W-1:0] slotIdx;
  ctl_t             ctl;

  prio_res_decode #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) uDec (
    .addr(regAddr), .isStatus(isStatus), .isSlot(isSlot), .slotIdx(slotIdx)
  );

  prio_res_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .isStatus(isStatus), .lastSlot(lastSlot), .ctl(ctl), .busy(regBusy)
  );

  prio_res_dp #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .isSlot(isSlot), .slotIdx(slotIdx),
    .regWrData(regWrData),
    .pendIn({pendHi, pendLo}), .enIn({enHi, enLo}), .fiqIn({fiqHi, fiqLo}),
    .lastSlot(lastSlot), .regRdData(regRdData), .regRdValid(regRdValid)
  );
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk
  import prio_resolver_pkg::*;
#(
  parameter int NUM_SRC = DEF_NUM_SRC
) (
  input logic              clk,
  input logic              rstN,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regRdData,
  input logic              regRdValid,
  input logic              regBusy
);
  int unsigned busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)        busyRun <= 0;
    else if (regBusy) busyRun <= busyRun + 1;
    else              busyRun <= 0;
  end

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(regBusy) |-> (busyRun == unsigned'(NUM_SRC + 1)) && regRdValid);

  // R4
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdValid |-> !regBusy);

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regBusy) |-> $past(regRdEn) && ($past(regAddr) == STAT_OFS));

  // R3
  slot_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!regBusy && regRdEn && regAddr != STAT_OFS) |=> regRdValid && !regBusy);

  // R7
  status_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(regBusy) |-> (regRdData[FIQ_VLD_BIT-1:ID_W] == '0) &&
                       (regRdData[IRQ_VLD_BIT-1:IRQ_ID_LSB+ID_W] == '0));

  // R8
  fiq_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(regBusy) && !regRdData[FIQ_VLD_BIT]) |-> regRdData[ID_W-1:0] == NONE_ID);

  // R8
  irq_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(regBusy) && !regRdData[IRQ_VLD_BIT]) |->
      regRdData[IRQ_ID_LSB +: ID_W] == NONE_ID);
endmodule

bind prio_resolver prio_resolver_chk #(.NUM_SRC(NUM_SRC)) uChk (
  .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .regAddr(regAddr),
  .regRdData(regRdData), .regRdValid(regRdValid), .regBusy(regBusy)
);

// File: tb/sim_prio_resolver.sv
`timescale 1ns/1ps
module sim_prio_resolver;
  localparam int NSRC = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] pLo = '0, eLo = '0, fLo = '0;
  logic [7:0]  pHi = '0, eHi = '0, fHi = '0;
  logic [31:0] rdData;
  logic        rdValid, busy;

  prio_resolver u0 (
    .clk(clk), .rstN(rstN), .regWrEn(wrEn), .regRdEn(rdEn), .regAddr(addr),
    .regWrData(wdata), .regRdData(rdData), .regRdValid(rdValid), .regBusy(busy),
    .pendLo(pLo), .pendHi(pHi), .enLo(eLo), .enHi(eHi), .fiqLo(fLo), .fiqHi(fHi)
  );

  always #10 clk = ~clk;

  int          nChecks = 0, nFail = 0, cyc = 0;
  string       curReq = "R1";
  logic [31:0] mSlot [NSRC];
  int          remain = 0;
  logic [31:0] pendRes = '0;
  logic        expBusy = 1'b0, expValid = 1'b0;
  logic [31:0] expData = '0;
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int slotOf(logic [7:0] a);
    if (a[1:0] != 0) return -1;
    if (a >= 8'h1C && a < 8'h9C) return (int'(a) - 'h1C) / 4;
    if (a >= 8'hB0 && a < 8'hD0) return 32 + (int'(a) - 'hB0) / 4;
    return -1;
  endfunction

  function automatic logic [7:0] slotAddr(int n);
    return (n < 32) ? 8'(8'h1C + 4 * n) : 8'(8'hB0 + 4 * (n - 32));
  endfunction

  function automatic logic bitOf(logic [31:0] lo, logic [7:0] hi, int id);
    return (id < 32) ? lo[id] : hi[id - 32];
  endfunction

  function automatic logic [31:0] model_status();
    logic fFound = 0, iFound = 0;
    int   fId = 63, iId = 63;
    for (int i = 0; i < NSRC; i++) begin
      int id = int'(mSlot[i][5:0]);
      if (mSlot[i][31] && id < NSRC && bitOf(pLo, pHi, id) && bitOf(eLo, eHi, id)) begin
        if (bitOf(fLo, fHi, id)) begin
          if (!fFound) begin fFound = 1; fId = id; end
        end else if (!iFound) begin
          iFound = 1; iId = id;
        end
      end
    end
    return {iFound, 9'd0, 6'(iId), fFound, 9'd0, 6'(fId)};
  endfunction

  task automatic model_step();
    logic [31:0] oldRd;
    int s;
    expValid = 1'b0;
    if (remain > 0) begin
      remain--;
      if (remain == 0) begin expValid = 1'b1; expData = pendRes; end
    end else begin
      s = slotOf(addr);
      oldRd = (s >= 0) ? mSlot[s] : 32'h0;
      if (wrEn && s >= 0) mSlot[s] = wdata & 32'h8000_003F;
      if (rdEn) begin
        if (addr == 8'h18) begin
          pendRes = model_status();
          remain  = NSRC + 1;
        end else begin
          expValid = 1'b1; expData = oldRd;
        end
      end
    end
    expBusy = (remain > 0);
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check({curReq, " busy"}, {31'd0, busy}, {31'd0, expBusy});
    check({curReq, " rdValid"}, {31'd0, rdValid}, {31'd0, expValid});
    if (expValid) check({curReq, " rdData"}, rdData, expData);
  endtask

  task automatic op(logic w, logic r, logic [7:0] a, logic [31:0] d);
    wrEn = w; rdEn = r; addr = a; wdata = d;
    tick();
    wrEn = 0; rdEn = 0;
  endtask

  task automatic put_slot(int n, logic [31:0] v);
    op(1, 0, slotAddr(n), v);
  endtask

  task automatic get_slot(int n);
    op(0, 1, slotAddr(n), 32'h0);
    tick();
  endtask

  task automatic status_read();
    op(0, 1, 8'h18, 32'h0);
    while (remain > 0) tick();
    tick();
  endtask

  task automatic clear_slots();
    for (int i = 0; i < NSRC; i++) put_slot(i, 32'h0);
  endtask

  function automatic logic [31:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog R4: actual no completion expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NSRC; i++) mSlot[i] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    curReq = "R1";
    check("R1 busy after reset", {31'd0, busy}, 32'd0);
    check("R1 rdValid after reset", {31'd0, rdValid}, 32'd0);
    pLo = '1; eLo = '1; pHi = '1; eHi = '1;
    get_slot(0);
    get_slot(39);
    status_read();                                   // R1: 0x003F003F expected

    // R2 masked storage and both address windows
    curReq = "R2";
    put_slot(0, 32'hFFFF_FFFF);
    get_slot(0);
    put_slot(35, 32'h7FFF_FFE1);
    get_slot(35);
    put_slot(31, 32'h8000_0021);
    get_slot(31);

    // R3 unmapped reads, ignored writes, read-before-write
    curReq = "R3";
    op(1, 0, 8'h18, 32'h8000_0005);
    op(1, 0, 8'h00, 32'h8000_0005);
    op(1, 0, 8'h1E, 32'h8000_0005);
    op(0, 1, 8'h04, 32'h0);
    op(0, 1, 8'h9C, 32'h0);
    get_slot(0);
    op(1, 1, slotAddr(0), 32'h8000_0002);            // old value expected
    tick();
    get_slot(0);
    clear_slots();

    // R5 skipped slots: invalid flag, ID 40 and above
    curReq = "R5";
    fLo = 32'h0; fHi = 8'h0;
    put_slot(0, 32'h0000_0003);
    put_slot(1, 32'h8000_002D);
    put_slot(2, 32'h8000_0028);
    put_slot(3, 32'h8000_0007);
    status_read();                                   // IRQ id 7, FIQ empty
    clear_slots();

    // R6/R7 ranking and steering
    curReq = "R6";
    pLo = 32'h0000_00FF; eLo = 32'h0000_00F7; fLo = 32'h0000_00F0;
    pHi = 0; eHi = 0; fHi = 0;
    put_slot(0, 32'h8000_0003);                      // disabled, skipped
    put_slot(1, 32'h8000_0006);                      // FIQ winner
    put_slot(2, 32'h8000_0001);                      // IRQ winner
    put_slot(3, 32'h8000_0004);
    put_slot(4, 32'h8000_0002);
    status_read();
    curReq = "R7";
    fLo = 32'h0; status_read();                      // all IRQ: id 6, FIQ empty
    fLo = 32'hFFFF_FFFF; status_read();              // all FIQ: id 6, IRQ empty
    clear_slots();

    // R8 empty halves
    curReq = "R8";
    pLo = 0; pHi = 0;
    put_slot(5, 32'h8000_0009);
    status_read();

    // R9 high bank
    curReq = "R9";
    pLo = 32'h0000_0002; eLo = '1; fLo = 0;
    pHi = 8'h02; eHi = 8'hFF; fHi = 8'h02;
    put_slot(6, 32'h8000_0021);                      // id 33 -> hi bit1, FIQ
    put_slot(7, 32'h8000_0001);                      // id 1, IRQ
    put_slot(8, 32'h8000_0027);
    status_read();
    fHi = 8'h00; pHi = 8'h80; fLo = 32'h0000_0002;   // id 39 only on hi bit7
    put_slot(6, 32'h8000_0027);
    status_read();
    clear_slots();

    // R10 inputs sampled at the request
    curReq = "R10";
    pLo = 32'h0000_0010; eLo = '1; fLo = 0; pHi = 0;
    put_slot(0, 32'h8000_0004);
    put_slot(1, 32'h8000_0005);
    op(0, 1, 8'h18, 32'h0);
    pLo = 32'h0000_0020; fLo = '1;
    while (remain > 0) tick();
    tick();

    // R11 accesses while busy are dropped
    curReq = "R11";
    op(0, 1, 8'h18, 32'h0);
    op(1, 0, slotAddr(0), 32'h8000_0011);
    op(0, 1, slotAddr(1), 32'h0);
    op(1, 1, 8'h18, 32'h8000_0011);
    while (remain > 0) tick();
    tick();
    get_slot(0);
    clear_slots();

    // R6 pseudo-random patterns
    curReq = "R6";
    for (int r = 0; r < 25; r++) begin
      for (int k = 0; k < 8; k++) begin
        logic [31:0] v;
        v = rnd();
        put_slot(int'(v[15:8]) % NSRC, {v[31], 25'd0, 6'(int'(v[5:0]) % 48)});
      end
      pLo = rnd() & rnd(); eLo = rnd() | rnd(); fLo = rnd();
      pHi = 8'(rnd()); eHi = 8'(rnd()); fHi = 8'(rnd());
      status_read();
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule